// File: doc/BRIEF.md
# ATM Receive Reassembly Channel Controller

This block follows packet reassembly for a set of ATM receive channels, one cell at a time. A classifier upstream has already picked the channel. The block receives that channel number, the 32-bit cell header (HEC removed) and the 48-byte payload. For each channel a state table holds the following fields:

- enable
- reassembly mode
- active flag
- wait-for-end flag
- transparent cell down-counter and its reload length
- start-buffer pointer

At packet start the block asks an external free-buffer pool for a buffer. The pool answers in the same cycle. Each stored cell is emitted with start and end markers and the start-buffer pointer, so a downstream writer can fill the buffer control word.

End of packet is found in one of two ways, chosen per channel:

- **Counter mode:** a per-channel down-counter reaches zero.
- **PTI and AAL5 modes:** the header carries the end-of-frame indication.

On end of packet the block latches a completion record holding the channel, the header, the AAL5 trailer word and the start buffer. The record is held until the completion ring accepts it.

If a packet start finds no free buffer, the channel drops cells until the end of that packet. It then starts afresh. A narrow configuration write port programs a channel's enable, mode and length.

Top module: `rx_reasm_ctrl`

## Requirements
- R1: After reset every channel is disabled, inactive and not waiting. `store_valid_o`, `cpl_valid_o` and `buf_req_o` are low and `cell_ready_o` is high.
- R2: A cell offered to a disabled channel produces no buffer request, no stored cell and no completion.
- R3: A cell for an enabled channel that is neither active nor waiting raises `buf_req_o` combinationally while it is offered. If `buf_avail_i` is high, one cycle after acceptance the cell is emitted with `store_sop_o`=1 and `store_buf_o` equal to the `buf_ptr_i` of that cycle.
- R4: If `buf_avail_i` is low at packet start, the cell is dropped. The channel then also drops later cells, without requesting buffers, up to and including the next end-of-packet cell. The cell after that starts a new packet. A failed start on a cell that is itself end of packet leaves the channel idle.
- R5: A cell arriving on an active channel is emitted with `store_sop_o`=0 and `store_buf_o` equal to the packet's start buffer. Channels keep independent state when their cells interleave.
- R6: Mode encoding is 0 for AAL5, 1 for PTI transparent and 2 for counter transparent (3 behaves as AAL5). In counter mode every accepted cell of an enabled channel decrements the counter. The cell that brings it to zero is end of packet, and the counter then reloads from the programmed length. Header PTI bits are ignored in this mode.
- R7: In AAL5 and PTI modes a cell is end of packet when header bit 1 is set. Bit 1 is the low PTI bit; the header layout is GFC/VPI[31:20], VCI[19:4], PTI[3:1], CLP[0].
- R8: An end-of-packet cell that is stored carries `store_eop_o`=1 and clears the active flag, so the next cell on that channel starts a new packet. A single cell may carry both markers.
- R9: One cycle after a stored end-of-packet cell is accepted, `cpl_valid_o` rises. The record carries:
  - the channel and the header;
  - the start buffer;
  - a trailer word made of payload bytes 40..43 (byte 0 at payload bits [383:376], so the trailer is bits [63:32]).
- R10: While `cpl_valid_o` is high and `cpl_ready_i` is low, the record is held unchanged. `cell_ready_o` is low whenever `cpl_valid_o` is high. With `cpl_ready_i` high the record lasts one cycle.
- R11: A configuration write sets the channel's enable, mode and length, loads the counter with the length, and clears active and wait-for-end. `cell_ready_o` is low in the cycle of a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_chan_i | input | CHAN_W | Channel being configured |
| cfg_en_i | input | 1 | Enable value |
| cfg_mode_i | input | 2 | Reassembly mode |
| cfg_len_i | input | CNT_W | Cells per packet in counter mode |
| cell_valid_i | input | 1 | Cell offered |
| cell_ready_o | output | 1 | Cell accepted when high with valid |
| cell_chan_i | input | CHAN_W | Channel of the cell |
| cell_hdr_i | input | 32 | Cell header |
| cell_payload_i | input | 8*CELL_BYTES | Payload, byte 0 in the top bits |
| buf_req_o | output | 1 | Free-buffer request |
| buf_avail_i | input | 1 | A free buffer is granted this cycle |
| buf_ptr_i | input | BUF_W | Granted buffer pointer |
| store_valid_o | output | 1 | Stored-cell strobe |
| store_chan_o | output | CHAN_W | Channel of stored cell |
| store_sop_o | output | 1 | Start-of-packet marker |
| store_eop_o | output | 1 | End-of-packet marker |
| store_buf_o | output | BUF_W | Buffer pointer of the packet |
| store_payload_o | output | 8*CELL_BYTES | Payload to store |
| cpl_valid_o | output | 1 | Completion record valid |
| cpl_ready_i | input | 1 | Completion record taken |
| cpl_chan_o | output | CHAN_W | Completion channel |
| cpl_hdr_o | output | 32 | Header of end-of-packet cell |
| cpl_trailer_o | output | 32 | AAL5 trailer word |
| cpl_buf_o | output | BUF_W | Start buffer of the packet |

## Verification
The buffer request is combinational, so it is sampled in the same low clock phase in which the cell is offered, before the accepting edge. The stored-cell outputs and a completion record come from registers loaded at the accepting edge. They are due one cycle later, and the monitor compares them at the falling edge that follows that edge. A dropped or ignored cell is checked by showing that no stored cell and no completion appear at that same falling edge. Backpressure is checked by holding the completion ready low for several falling edges while the record and `cell_ready_o` are watched, then confirming the record clears one cycle after ready returns.

// File: rtl/rx_reasm_pkg.sv
package rx_reasm_pkg;
  typedef enum logic [1:0] {
    MODE_AAL5 = 2'd0,
    MODE_PTI  = 2'd1,
    MODE_CNT  = 2'd2,
    MODE_RSVD = 2'd3
  } rmode_e;
endpackage

// File: rtl/rx_reasm_chan_tbl.sv
module rx_reasm_chan_tbl
  import rx_reasm_pkg::*;
#(
  parameter int NUM_CHAN = 16,
  parameter int CNT_W    = 8,
  parameter int BUF_W    = 16,
  localparam int CHAN_W  = $clog2(NUM_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CHAN_W-1:0] cfg_idx_i,
  input  logic              cfg_en_i,
  input  rmode_e            cfg_mode_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  input  logic              upd_we_i,
  input  logic [CHAN_W-1:0] upd_idx_i,
  input  logic [CNT_W-1:0]  upd_cnt_i,
  input  logic              upd_act_i,
  input  logic              upd_wait_i,
  input  logic [BUF_W-1:0]  upd_sbuf_i,
  input  logic [CHAN_W-1:0] rd_idx_i,
  output logic              rd_en_o,
  output rmode_e            rd_mode_o,
  output logic [CNT_W-1:0]  rd_len_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              rd_act_o,
  output logic              rd_wait_o,
  output logic [BUF_W-1:0]  rd_sbuf_o
);
  logic [NUM_CHAN-1:0] en_v, act_v, wait_v;
  rmode_e              mode_v [NUM_CHAN];
  logic [CNT_W-1:0]    len_v  [NUM_CHAN];
  logic [CNT_W-1:0]    cnt_v  [NUM_CHAN];
  logic [BUF_W-1:0]    sbuf_v [NUM_CHAN];

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_ent
    logic             en_q, act_q, wait_q;
    rmode_e           mode_q;
    logic [CNT_W-1:0] len_q, cnt_q;
    logic [BUF_W-1:0] sbuf_q;
    logic             cfg_hit, upd_hit;

    assign cfg_hit = cfg_we_i && (cfg_idx_i == CHAN_W'(g));
    assign upd_hit = upd_we_i && (upd_idx_i == CHAN_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        act_q  <= 1'b0;
        wait_q <= 1'b0;
        mode_q <= MODE_AAL5;
        len_q  <= '0;
        cnt_q  <= '0;
        sbuf_q <= '0;
      end else if (cfg_hit) begin
        en_q   <= cfg_en_i;
        mode_q <= cfg_mode_i;
        len_q  <= cfg_len_i;
        cnt_q  <= cfg_len_i;
        act_q  <= 1'b0;
        wait_q <= 1'b0;
      end else if (upd_hit) begin
        cnt_q  <= upd_cnt_i;
        act_q  <= upd_act_i;
        wait_q <= upd_wait_i;
        sbuf_q <= upd_sbuf_i;
      end
    end

    assign en_v[g]   = en_q;
    assign act_v[g]  = act_q;
    assign wait_v[g] = wait_q;
    assign mode_v[g] = mode_q;
    assign len_v[g]  = len_q;
    assign cnt_v[g]  = cnt_q;
    assign sbuf_v[g] = sbuf_q;
  end

  assign rd_en_o   = en_v[rd_idx_i];
  assign rd_act_o  = act_v[rd_idx_i];
  assign rd_wait_o = wait_v[rd_idx_i];
  assign rd_mode_o = mode_v[rd_idx_i];
  assign rd_len_o  = len_v[rd_idx_i];
  assign rd_cnt_o  = cnt_v[rd_idx_i];
  assign rd_sbuf_o = sbuf_v[rd_idx_i];

  // R4
  act_wait_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_act_o && rd_wait_o));
endmodule

// File: rtl/rx_reasm_eop_det.sv
module rx_reasm_eop_det
  import rx_reasm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  rmode_e           mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             pti_end_i,
  output logic             eop_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_dec;

  always_comb begin
    cnt_dec   = cnt_i - CNT_W'(1);
    eop_o     = pti_end_i;
    cnt_nxt_o = cnt_i;
    if (mode_i == MODE_CNT) begin
      eop_o     = (cnt_dec == '0);
      cnt_nxt_o = eop_o ? len_i : cnt_dec;
    end
  end
endmodule

// File: rtl/rx_reasm_cpl_reg.sv
module rx_reasm_cpl_reg #(
  parameter int CHAN_W = 4,
  parameter int BUF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [31:0]       hdr_i,
  input  logic [31:0]       trailer_i,
  input  logic [BUF_W-1:0]  buf_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic [31:0]       hdr_o,
  output logic [31:0]       trailer_o,
  output logic [BUF_W-1:0]  buf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      chan_o    <= '0;
      hdr_o     <= '0;
      trailer_o <= '0;
      buf_o     <= '0;
    end else if (load_i) begin
      valid_o   <= 1'b1;
      chan_o    <= chan_i;
      hdr_o     <= hdr_i;
      trailer_o <= trailer_i;
      buf_o     <= buf_i;
    end else if (ready_i) begin
      valid_o   <= 1'b0;
    end
  end

  // R10
  cpl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(trailer_o) && $stable(hdr_o) && $stable(buf_o));
endmodule

// File: rtl/rx_reasm_ctrl.sv
module rx_reasm_ctrl
  import rx_reasm_pkg::*;
#(
  parameter int NUM_CHAN   = 16,
  parameter int CNT_W      = 8,
  parameter int BUF_W      = 16,
  parameter int CELL_BYTES = 48,
  parameter int TRL_OFS    = 40,
  localparam int CHAN_W    = $clog2(NUM_CHAN),
  localparam int PAY_W     = CELL_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CHAN_W-1:0] cfg_chan_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  input  logic              cell_valid_i,
  output logic              cell_ready_o,
  input  logic [CHAN_W-1:0] cell_chan_i,
  input  logic [31:0]       cell_hdr_i,
  input  logic [PAY_W-1:0]  cell_payload_i,
  output logic              buf_req_o,
  input  logic              buf_avail_i,
  input  logic [BUF_W-1:0]  buf_ptr_i,
  output logic              store_valid_o,
  output logic [CHAN_W-1:0] store_chan_o,
  output logic              store_sop_o,
  output logic              store_eop_o,
  output logic [BUF_W-1:0]  store_buf_o,
  output logic [PAY_W-1:0]  store_payload_o,
  output logic              cpl_valid_o,
  input  logic              cpl_ready_i,
  output logic [CHAN_W-1:0] cpl_chan_o,
  output logic [31:0]       cpl_hdr_o,
  output logic [31:0]       cpl_trailer_o,
  output logic [BUF_W-1:0]  cpl_buf_o
);
  localparam int TRL_LSB = (CELL_BYTES - TRL_OFS - 4) * 8;
  localparam int PTI_END_BIT = 1;

  logic             rd_en, rd_act, rd_wait;
  rmode_e           rd_mode;
  logic [CNT_W-1:0] rd_len, rd_cnt, cnt_nxt;
  logic [BUF_W-1:0] rd_sbuf;
  logic             accept, live, eop, start_ok, do_store;
  logic             act_nxt, wait_nxt;
  logic [BUF_W-1:0] sbuf_nxt;

  rx_reasm_chan_tbl #(.NUM_CHAN(NUM_CHAN), .CNT_W(CNT_W), .BUF_W(BUF_W)) tbl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_chan_i),
    .cfg_en_i   (cfg_en_i),
    .cfg_mode_i (rmode_e'(cfg_mode_i)),
    .cfg_len_i  (cfg_len_i),
    .upd_we_i   (live),
    .upd_idx_i  (cell_chan_i),
    .upd_cnt_i  (cnt_nxt),
    .upd_act_i  (act_nxt),
    .upd_wait_i (wait_nxt),
    .upd_sbuf_i (sbuf_nxt),
    .rd_idx_i   (cell_chan_i),
    .rd_en_o    (rd_en),
    .rd_mode_o  (rd_mode),
    .rd_len_o   (rd_len),
    .rd_cnt_o   (rd_cnt),
    .rd_act_o   (rd_act),
    .rd_wait_o  (rd_wait),
    .rd_sbuf_o  (rd_sbuf)
  );

  rx_reasm_eop_det #(.CNT_W(CNT_W)) eop_i (
    .mode_i    (rd_mode),
    .cnt_i     (rd_cnt),
    .len_i     (rd_len),
    .pti_end_i (cell_hdr_i[PTI_END_BIT]),
    .eop_o     (eop),
    .cnt_nxt_o (cnt_nxt)
  );

  // cells stall while a completion is pending or a channel is being reconfigured
  assign cell_ready_o = !cpl_valid_o && !cfg_we_i;
  assign accept       = cell_valid_i && cell_ready_o;
  assign live         = accept && rd_en;
  assign buf_req_o    = live && !rd_act && !rd_wait;
  assign start_ok     = buf_req_o && buf_avail_i;
  assign do_store     = live && !rd_wait && (rd_act || buf_avail_i);
  assign sbuf_nxt     = start_ok ? buf_ptr_i : rd_sbuf;

  always_comb begin
    act_nxt  = 1'b0;
    wait_nxt = 1'b0;
    if (rd_wait) begin
      wait_nxt = !eop;
    end else if (!rd_act) begin
      act_nxt  = buf_avail_i && !eop;
      wait_nxt = !buf_avail_i && !eop;
    end else begin
      act_nxt  = !eop;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_valid_o   <= 1'b0;
      store_chan_o    <= '0;
      store_sop_o     <= 1'b0;
      store_eop_o     <= 1'b0;
      store_buf_o     <= '0;
      store_payload_o <= '0;
    end else begin
      store_valid_o <= do_store;
      if (do_store) begin
        store_chan_o    <= cell_chan_i;
        store_sop_o     <= !rd_act;
        store_eop_o     <= eop;
        store_buf_o     <= sbuf_nxt;
        store_payload_o <= cell_payload_i;
      end
    end
  end

  rx_reasm_cpl_reg #(.CHAN_W(CHAN_W), .BUF_W(BUF_W)) cpl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (do_store && eop),
    .chan_i    (cell_chan_i),
    .hdr_i     (cell_hdr_i),
    .trailer_i (cell_payload_i[TRL_LSB +: 32]),
    .buf_i     (sbuf_nxt),
    .valid_o   (cpl_valid_o),
    .ready_i   (cpl_ready_i),
    .chan_o    (cpl_chan_o),
    .hdr_o     (cpl_hdr_o),
    .trailer_o (cpl_trailer_o),
    .buf_o     (cpl_buf_o)
  );

  // R3
  sop_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_valid_o && store_sop_o |-> $past(buf_req_o && buf_avail_i));
  // R2
  store_from_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_valid_o |-> $past(cell_valid_i && cell_ready_o));
  // R9
  eop_posts_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_valid_o && store_eop_o |-> cpl_valid_o && cpl_chan_o == store_chan_o);
  // R11
  cfg_blocks_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !store_valid_o);
endmodule

// File: tb/rx_reasm_ctrl_tb_top.sv
module rx_reasm_ctrl_tb_top;
  localparam int CHAN_W = 4;
  localparam int CNT_W  = 8;
  localparam int BUF_W  = 16;
  localparam int PAY_W  = 384;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CHAN_W-1:0] cfg_chan = '0;
  logic              cfg_en = 1'b0;
  logic [1:0]        cfg_mode = '0;
  logic [CNT_W-1:0]  cfg_len = '0;
  logic              cell_valid = 1'b0;
  logic              cell_ready;
  logic [CHAN_W-1:0] cell_chan = '0;
  logic [31:0]       cell_hdr = '0;
  logic [PAY_W-1:0]  cell_pay = '0;
  logic              buf_req;
  logic              buf_avail = 1'b0;
  logic [BUF_W-1:0]  buf_ptr = '0;
  logic              st_valid, st_sop, st_eop;
  logic [CHAN_W-1:0] st_chan;
  logic [BUF_W-1:0]  st_buf;
  logic [PAY_W-1:0]  st_pay;
  logic              cpl_valid;
  logic              cpl_ready = 1'b1;
  logic [CHAN_W-1:0] cpl_chan;
  logic [31:0]       cpl_hdr, cpl_trl;
  logic [BUF_W-1:0]  cpl_buf;

  always #10 clk = ~clk;

  rx_reasm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_chan_i(cfg_chan), .cfg_en_i(cfg_en),
    .cfg_mode_i(cfg_mode), .cfg_len_i(cfg_len),
    .cell_valid_i(cell_valid), .cell_ready_o(cell_ready), .cell_chan_i(cell_chan),
    .cell_hdr_i(cell_hdr), .cell_payload_i(cell_pay),
    .buf_req_o(buf_req), .buf_avail_i(buf_avail), .buf_ptr_i(buf_ptr),
    .store_valid_o(st_valid), .store_chan_o(st_chan), .store_sop_o(st_sop),
    .store_eop_o(st_eop), .store_buf_o(st_buf), .store_payload_o(st_pay),
    .cpl_valid_o(cpl_valid), .cpl_ready_i(cpl_ready), .cpl_chan_o(cpl_chan),
    .cpl_hdr_o(cpl_hdr), .cpl_trailer_o(cpl_trl), .cpl_buf_o(cpl_buf)
  );

  typedef struct {
    int ch; int bptr; bit sop; bit eop; logic [PAY_W-1:0] pay;
  } st_item_t;
  typedef struct {
    int ch; logic [31:0] hdr; logic [31:0] trl; int bptr;
  } cpl_item_t;

  st_item_t  st_q[$];
  cpl_item_t cpl_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference channel state built from the requirements
  bit m_en[16], m_act[16], m_wait[16];
  int m_mode[16], m_len[16], m_cnt[16], m_sbuf[16];

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [PAY_W-1:0] mk_pay(input int seed);
    logic [PAY_W-1:0] p;
    for (int k = 0; k < 48; k++) p[PAY_W-1-8*k -: 8] = 8'(seed * 7 + k * 3);
    return p;
  endfunction

  function automatic logic [31:0] trl_of(input logic [PAY_W-1:0] p);
    return {p[PAY_W-1-8*40 -: 8], p[PAY_W-1-8*41 -: 8],
            p[PAY_W-1-8*42 -: 8], p[PAY_W-1-8*43 -: 8]};
  endfunction

  task automatic cfg(input int ch, input bit en, input int mode, input int len);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 4'(ch); cfg_en = en; cfg_mode = 2'(mode); cfg_len = 8'(len);
    #1;
    chk(cell_ready == 1'b0, "R11", $sformatf("cell_ready during cfg act=%0b exp=0", cell_ready));
    m_en[ch] = en; m_mode[ch] = mode; m_len[ch] = len; m_cnt[ch] = len;
    m_act[ch] = 1'b0; m_wait[ch] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int ch, input bit pti_end, input int seed,
                      input bit avail, input int ptr, input string req);
    bit eop, exp_req, exp_store;
    st_item_t si;
    cpl_item_t ci;
    @(negedge clk);
    while (!cell_ready) @(negedge clk);
    cell_valid = 1'b1; cell_chan = 4'(ch);
    cell_hdr = {12'h0A5, 16'(ch + 32), 1'b0, 1'b0, pti_end, 1'b0};
    cell_pay = mk_pay(seed);
    buf_avail = avail; buf_ptr = 16'(ptr);
    exp_req = 1'b0; exp_store = 1'b0;
    eop = (m_mode[ch] == 2) ? (m_cnt[ch] == 1) : pti_end;
    if (m_en[ch]) begin
      if (m_mode[ch] == 2) m_cnt[ch] = eop ? m_len[ch] : ((m_cnt[ch] - 1) & 8'hFF);
      if (m_wait[ch]) begin
        if (eop) m_wait[ch] = 1'b0;
      end else if (!m_act[ch]) begin
        exp_req = 1'b1;
        if (avail) begin
          m_sbuf[ch] = ptr; exp_store = 1'b1;
          si = '{ch, ptr, 1'b1, eop, cell_pay};
          m_act[ch] = !eop;
        end else if (!eop) m_wait[ch] = 1'b1;
      end else begin
        exp_store = 1'b1;
        si = '{ch, m_sbuf[ch], 1'b0, eop, cell_pay};
        if (eop) m_act[ch] = 1'b0;
      end
      if (exp_store) begin
        st_q.push_back(si);
        if (eop) begin
          ci = '{ch, cell_hdr, trl_of(cell_pay), m_sbuf[ch]};
          cpl_q.push_back(ci);
        end
      end
    end
    #1;
    chk(buf_req == exp_req, req, $sformatf("buf_req ch%0d act=%0b exp=%0b", ch, buf_req, exp_req));
    @(posedge clk);
    @(negedge clk);
    cell_valid = 1'b0; buf_avail = 1'b0;
    if (!exp_store)
      chk(!st_valid && !cpl_valid, req,
          $sformatf("dropped cell ch%0d produced output st=%0b cpl=%0b exp=0/0", ch, st_valid, cpl_valid));
  endtask

  // monitor: compares outputs with the scoreboard
  bit cpl_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (st_valid) begin
        if (st_q.size() == 0) chk(1'b0, "R5", "unexpected stored cell act=1 exp=none");
        else begin
          st_item_t e;
          e = st_q.pop_front();
          chk(int'(st_chan) == e.ch && int'(st_buf) == e.bptr && st_sop == e.sop &&
              st_eop == e.eop && st_pay == e.pay, "R5",
              $sformatf("store ch/buf/sop/eop act=%0d/%0h/%0b/%0b exp=%0d/%0h/%0b/%0b",
                        st_chan, st_buf, st_sop, st_eop, e.ch, e.bptr, e.sop, e.eop));
        end
      end
      if (cpl_valid && !cpl_prev) begin
        if (cpl_q.size() == 0) chk(1'b0, "R9", "unexpected completion act=1 exp=none");
        else begin
          cpl_item_t c;
          c = cpl_q.pop_front();
          chk(int'(cpl_chan) == c.ch && cpl_hdr == c.hdr && cpl_trl == c.trl &&
              int'(cpl_buf) == c.bptr, "R9",
              $sformatf("cpl ch/hdr/trl/buf act=%0d/%h/%h/%0h exp=%0d/%h/%h/%0h",
                        cpl_chan, cpl_hdr, cpl_trl, cpl_buf, c.ch, c.hdr, c.trl, c.bptr));
        end
      end
      cpl_prev = cpl_valid;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_trl;
    for (int i = 0; i < 16; i++) begin
      m_en[i] = 0; m_act[i] = 0; m_wait[i] = 0; m_mode[i] = 0; m_len[i] = 0; m_cnt[i] = 0; m_sbuf[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cell_ready && !st_valid && !cpl_valid && !buf_req, "R1",
        $sformatf("reset rdy/st/cpl/req act=%0b/%0b/%0b/%0b exp=1/0/0/0", cell_ready, st_valid, cpl_valid, buf_req));
    rst_n = 1'b1;
    send(0, 1'b1, 1, 1'b1, 16'h10, "R1");        // cleared table: channel 0 disabled

    // R3 R5 R7 R8 R9: PTI-mode three-cell packet
    cfg(1, 1'b1, 1, 0);
    send(1, 1'b0, 2, 1'b1, 16'h100, "R3");
    send(1, 1'b0, 3, 1'b1, 16'h999, "R5");
    send(1, 1'b1, 4, 1'b1, 16'h999, "R7");
    send(1, 1'b0, 5, 1'b1, 16'h110, "R8");       // new packet starts after eop
    send(1, 1'b1, 6, 1'b0, 16'h0, "R8");

    // R6 counter mode, length 3, PTI bit ignored, reload checked by second packet
    cfg(2, 1'b1, 2, 3);
    send(2, 1'b1, 7, 1'b1, 16'h200, "R6");
    send(2, 1'b1, 8, 1'b0, 16'h0, "R6");
    send(2, 1'b0, 9, 1'b0, 16'h0, "R6");
    send(2, 1'b0, 10, 1'b1, 16'h210, "R6");
    // R5 interleave channel 1 and 2
    send(1, 1'b0, 11, 1'b1, 16'h120, "R5");
    send(2, 1'b0, 12, 1'b0, 16'h0, "R5");
    send(1, 1'b1, 13, 1'b0, 16'h0, "R5");
    send(2, 1'b0, 14, 1'b0, 16'h0, "R6");

    // R4 failed start in AAL5 mode
    cfg(3, 1'b1, 0, 0);
    send(3, 1'b0, 15, 1'b0, 16'h0, "R4");
    send(3, 1'b0, 16, 1'b1, 16'h300, "R4");
    send(3, 1'b1, 17, 1'b1, 16'h300, "R4");
    send(3, 1'b0, 18, 1'b1, 16'h310, "R4");
    send(3, 1'b1, 19, 1'b1, 16'h0, "R4");
    send(3, 1'b1, 20, 1'b0, 16'h0, "R4");        // failed single-cell packet
    send(3, 1'b1, 21, 1'b1, 16'h320, "R8");      // single cell carries both markers

    // R4 counter-mode wait tracks the counter, mode 3 behaves as AAL5
    cfg(6, 1'b1, 2, 2);
    send(6, 1'b0, 22, 1'b0, 16'h0, "R4");
    send(6, 1'b0, 23, 1'b1, 16'h600, "R4");
    send(6, 1'b0, 24, 1'b1, 16'h610, "R6");
    send(6, 1'b0, 25, 1'b1, 16'h0, "R6");
    cfg(7, 1'b1, 3, 9);
    send(7, 1'b1, 26, 1'b1, 16'h700, "R7");

    // R2 disabled channel
    cfg(4, 1'b0, 1, 0);
    send(4, 1'b0, 27, 1'b1, 16'h400, "R2");
    send(4, 1'b1, 28, 1'b1, 16'h400, "R2");

    // R11 reconfiguration clears active
    cfg(5, 1'b1, 1, 0);
    send(5, 1'b0, 29, 1'b1, 16'h500, "R11");
    cfg(5, 1'b1, 1, 0);
    send(5, 1'b1, 30, 1'b1, 16'h510, "R11");

    // R10 backpressure
    @(negedge clk);
    cpl_ready = 1'b0;
    send(1, 1'b1, 31, 1'b1, 16'h130, "R10");
    held_trl = cpl_trl;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cpl_valid && !cell_ready && cpl_trl == held_trl, "R10",
          $sformatf("hold v/rdy/trl act=%0b/%0b/%h exp=1/0/%h", cpl_valid, cell_ready, cpl_trl, held_trl));
    end
    cpl_ready = 1'b1;
    @(negedge clk);
    chk(!cpl_valid && cell_ready, "R10",
        $sformatf("release v/rdy act=%0b/%0b exp=0/1", cpl_valid, cell_ready));

    repeat (3) @(negedge clk);
    chk(st_q.size() == 0 && cpl_q.size() == 0, "R9",
        $sformatf("pending items act=%0d/%0d exp=0/0", st_q.size(), cpl_q.size()));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule